// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block produces the low address bits for a synchronous memory that can serve several accesses from one supplied address. A load cycle captures the low bits of the new starting address. Each later advance cycle moves to the next address in the burst. The upper address bits and the storage array are handled elsewhere.

The order of the burst is picked by a mode input. Linear order counts upward and wraps within an aligned group. Interleaved order combines the starting value with a running step count by bitwise XOR. The mode is captured only on the load cycle. When the clock enable is low the block holds its state. With the default width of two bits, one load covers four accesses. Advancing past the end of the group wraps back to the starting address.

Top module: `burst_seq`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock edge) is applied, `cur_addr` becomes 0 and `burst_active` becomes 0 at the next edge.
- R2: An edge with `clk_en`=1 and `adv_ld`=0 loads a burst. After that edge `cur_addr` equals the `ld_addr` value that was sampled, `burst_active` is 1, and the step count restarts at 0. This also applies when a burst is already in progress.
- R3: With linear order captured (`order_sel`=0 at load), each advance edge (`clk_en`=1, `adv_ld`=1) sets `cur_addr` to its previous value plus one, modulo 2^BURST_BITS.
- R4: With interleaved order captured (`order_sel`=1 at load), the n-th advance after a load gives `cur_addr` = start XOR n, where n is taken modulo 2^BURST_BITS.
- R5: With BURST_BITS=2, one load supplies four distinct addresses. The fourth advance after a load returns `cur_addr` to the start value, in both orders.
- R6: An edge with `clk_en`=0 leaves `cur_addr` and `burst_active` unchanged, whatever `adv_ld`, `order_sel` and `ld_addr` are.
- R7: `order_sel` is used only on load edges. Changing it during a burst does not change the sequence that follows.
- R8: Advance edges that come before the first load after reset are ignored: `cur_addr` stays 0 and `burst_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock qualifier; 0 holds all state |
| adv_ld | input | 1 | 0 = load a new start address, 1 = advance the burst |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order; captured on load |
| ld_addr | input | BURST_BITS | Low address bits of the new start address |
| cur_addr | output | BURST_BITS | Current low address bits of the burst |
| burst_active | output | 1 | 1 once a start address has been loaded since reset |

## Verification
The bound checker checks these properties on every cycle: a load captures the address, a low clock enable holds state, an advance adds one in linear order, an interleaved advance changes the address by the XOR of consecutive step counts, and advances before any load are ignored. Some behaviours span several cycles: wrapping back to the start after four accesses, the exact sequence for every start value in both orders, the mode being ignored during a burst, and a reload in the middle of a burst. Only the bench's exhaustive sweeps show these, comparing each cycle against arithmetically computed addresses.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: order encoding 0 = linear, 1 = interleaved, matching the order_sel pin.
package burst_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/burst_step_ctr.sv
// Module: burst_step_ctr
// Holds the captured start address, the order and the step count of the current burst.
// Assumes: rst_n is synchronous and active low. A load takes priority over an advance.
// Advances are ignored until a start address has been loaded.
module burst_step_ctr
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  adv_ld,
    input  order_e                order_in,
    input  logic [BURST_BITS-1:0] start_in,
    output logic [BURST_BITS-1:0] start_q,
    output logic [BURST_BITS-1:0] step_q,
    output order_e                order_q,
    output logic                  valid_q
);
    logic do_load;
    logic do_adv;

    // Decode the qualified load and advance requests for this edge.
    always_comb begin
        do_load = clk_en && !adv_ld;
        do_adv  = clk_en && adv_ld && valid_q;
    end

    // Capture the burst context on load, step it on advance, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            step_q  <= '0;
            order_q <= ORD_LINEAR;
            valid_q <= 1'b0;
        end else if (do_load) begin
            start_q <= start_in;
            step_q  <= '0;
            order_q <= order_in;
            valid_q <= 1'b1;
        end else if (do_adv) begin
            step_q  <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start address and the step count to the current address in the chosen order.
// Assumes: purely combinational. Both orders wrap within the aligned group of 2^BURST_BITS.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start,
    input  logic [BURST_BITS-1:0] step,
    input  order_e                order,
    output logic [BURST_BITS-1:0] addr
);
    logic [BURST_BITS-1:0] lin_addr;
    logic [BURST_BITS-1:0] ilv_addr;

    // Interleaved order: each address bit is the start bit flipped by the matching step bit.
    for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv_bit
        assign ilv_addr[b] = start[b] ^ step[b];
    end

    // Linear order: modular sum, the carry out of the group is dropped.
    always_comb begin
        lin_addr = start + step;
    end

    // Select the order captured at load time.
    always_comb begin
        addr = (order == ORD_INTERLEAVE) ? ilv_addr : lin_addr;
    end
endmodule

// File: rtl/burst_seq.sv
// Module: burst_seq (top)
// Burst address sequencer: loads the low address bits and steps through
// 2^BURST_BITS addresses in linear or interleaved order.
// Assumes: order_sel is static in use, but only its value on a load edge matters.
module burst_seq
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  adv_ld,
    input  logic                  order_sel,
    input  logic [BURST_BITS-1:0] ld_addr,
    output logic [BURST_BITS-1:0] cur_addr,
    output logic                  burst_active
);
    logic [BURST_BITS-1:0] start_q;
    logic [BURST_BITS-1:0] step_q;
    order_e                order_q;
    order_e                order_in;

    // Convert the raw mode pin into the order type.
    always_comb begin
        order_in = order_e'(order_sel);
    end

    burst_step_ctr #(.BURST_BITS(BURST_BITS)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .adv_ld   (adv_ld),
        .order_in (order_in),
        .start_in (ld_addr),
        .start_q  (start_q),
        .step_q   (step_q),
        .order_q  (order_q),
        .valid_q  (burst_active)
    );

    burst_order_map #(.BURST_BITS(BURST_BITS)) i_map (
        .start (start_q),
        .step  (step_q),
        .order (order_q),
        .addr  (cur_addr)
    );
endmodule

// File: rtl/burst_seq_chk.sv
// Module: burst_seq_chk
// Cycle-level properties of burst_seq, attached through bind.
// Assumes: it observes the top-level ports plus the captured order and step count.
module burst_seq_chk
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clk_en,
    input logic                  adv_ld,
    input logic [BURST_BITS-1:0] ld_addr,
    input logic [BURST_BITS-1:0] cur_addr,
    input logic                  burst_active,
    input order_e                order_q,
    input logic [BURST_BITS-1:0] step_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0) && !burst_active); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld) |=> (cur_addr == $past(ld_addr)) && burst_active && (step_q == '0)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && burst_active && order_q == ORD_LINEAR)
        |=> cur_addr == BURST_BITS'($past(cur_addr) + 1'b1)); // R3

    AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && burst_active && order_q == ORD_INTERLEAVE)
        |=> (cur_addr ^ $past(cur_addr)) == (BURST_BITS'($past(step_q) + 1'b1) ^ $past(step_q))); // R4

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(cur_addr) && $stable(burst_active)); // R6

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en && !adv_ld) |=> $stable(order_q)); // R7

    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && !burst_active) |=> (cur_addr == '0) && !burst_active); // R8
endmodule

bind burst_seq burst_seq_chk #(.BURST_BITS(BURST_BITS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en       (clk_en),
    .adv_ld       (adv_ld),
    .ld_addr      (ld_addr),
    .cur_addr     (cur_addr),
    .burst_active (burst_active),
    .order_q      (order_q),
    .step_q       (step_q)
);

// File: tb/test_burst_seq.sv
// Bench for burst_seq: exhaustive sweeps of start value and order, with
// expected addresses computed arithmetically from the requirements.
module test_burst_seq;
    localparam int BB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          adv_ld = 1'b0;
    logic          order_sel = 1'b0;
    logic [BB-1:0] ld_addr = '0;
    logic [BB-1:0] cur_addr;
    logic          burst_active;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state derived from the requirements.
    int m_start = 0;
    int m_step  = 0;
    int m_ilv   = 0;
    int m_valid = 0;

    always #10 clk = ~clk;

    burst_seq #(.BURST_BITS(BB)) i_burst_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .adv_ld       (adv_ld),
        .order_sel    (order_sel),
        .ld_addr      (ld_addr),
        .cur_addr     (cur_addr),
        .burst_active (burst_active)
    );

    function automatic int exp_addr();
        if (m_ilv != 0) return (m_start ^ m_step) & 3;
        return (m_start + m_step) % 4;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, check outputs mid-high phase.
    task automatic cyc(input string req, input bit rst, input bit ce, input bit al,
                       input bit md, input int a);
        @(negedge clk);
        rst_n = rst; clk_en = ce; adv_ld = al; order_sel = md; ld_addr = BB'(a);
        @(posedge clk);
        if (!rst) begin
            m_start = 0; m_step = 0; m_ilv = 0; m_valid = 0;
        end else if (ce) begin
            if (!al) begin
                m_start = a; m_step = 0; m_ilv = md; m_valid = 1;
            end else if (m_valid != 0) begin
                m_step = (m_step + 1) % 4;
            end
        end
        #5;
        check(req, int'(cur_addr), exp_addr());
        check(req, int'(burst_active), m_valid);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cyc("R1", 0, 1, 1, 1, 3);
        cyc("R1", 0, 0, 0, 0, 2);
        // R8: advances before any load are ignored
        for (int i = 0; i < 3; i++) cyc("R8", 1, 1, 1, i[0], i);
        // R2 R3 R4 R5: every start value in both orders, six advances each
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                cyc("R2", 1, 1, 0, md[0], s);
                for (int k = 0; k < 6; k++)
                    cyc(md != 0 ? "R4_R5" : "R3_R5", 1, 1, 1, md[0], 3 - s);
            end
        end
        // R6: clock enable low freezes, regardless of other inputs
        cyc("R2", 1, 1, 0, 0, 1);
        cyc("R3", 1, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc("R6", 1, 0, i[0], i[1], i);
        cyc("R3", 1, 1, 1, 0, 2);
        // R7: order pin toggled mid-burst has no effect
        cyc("R2", 1, 1, 0, 1, 2);
        for (int k = 0; k < 5; k++) cyc("R7", 1, 1, 1, ~k[0], 0);
        cyc("R2", 1, 1, 0, 0, 1);
        for (int k = 0; k < 5; k++) cyc("R7", 1, 1, 1, 1, 3);
        // R2: reload in mid-burst restarts the step count
        cyc("R2", 1, 1, 0, 1, 3);
        cyc("R4", 1, 1, 1, 1, 0);
        cyc("R4", 1, 1, 1, 1, 0);
        cyc("R2", 1, 1, 0, 0, 3);
        cyc("R3", 1, 1, 1, 0, 0);
        // R1: reset mid-burst clears and later advances are ignored again
        cyc("R1", 0, 1, 1, 0, 0);
        cyc("R8", 1, 1, 1, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule